// File: doc/BRIEF.md
# E3 Framing Error Event Counter

This block accumulates framing error events for the receive side of an E3 framer that uses the 10-bit frame alignment word. The framer supplies frame timing with a single-cycle strobe, along with the received alignment bits, the expected alignment word and the current out-of-frame indication. A 2-bit mode input selects what is counted. The choices are entries into the out-of-frame state, individual mismatched alignment bits, or whole alignment words that contain any mismatch.

The count is held in a saturating counter. A host samples it with a latch pulse. That pulse copies the running count into a holding register, which drives the output, and restarts the running count from zero in the same clock. No event is lost across the boundary, because an event present in the latch cycle is counted into the new interval. A separate count-enable input gates the two alignment-word modes only. Out-of-frame entries are counted whatever its setting.

Top module: `e3_fas_err_counter`

## Requirements
- R1: After reset, both the running count and `hold_count` are zero, and a latch taken before any event returns 0.
- R2: With mode 2'b00, each 0-to-1 transition of `oof` adds exactly one. Cycles in which `oof` stays high add nothing, and neither `count_en` nor `frame_stb` has any effect.
- R3: With mode 2'b01, on a cycle with `frame_stb`=1, `oof`=0 and `count_en`=1, the count grows by the number of bit positions in which `fas_rx` differs from `fas_exp`. This is 0 to 10 per frame, and bit 9 is the first bit received.
- R4: With mode 2'b10, under the same qualifying conditions as R3, the count grows by one if any bit of `fas_rx` differs from `fas_exp`, and by zero otherwise.
- R5: With mode 2'b11 (reserved), no input pattern changes the count.
- R6: In modes 2'b01 and 2'b10, a strobe adds nothing while `oof`=1 or `count_en`=0.
- R7: In modes 2'b01, 2'b10 and 2'b11, rising edges of `oof` add nothing. In mode 2'b00, alignment-word mismatches add nothing.
- R8: The running count is 16 bits wide and stops at 65535 instead of wrapping.
- R9: A cycle with `latch_req`=1 makes `hold_count` equal, from the next cycle, to the running count as it stood before that cycle. The running count is restarted at the same edge.
- R10: An event in the same cycle as `latch_req` is not included in the value latched by that pulse. It appears in the value returned by the next latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_stb | input | 1 | One-cycle pulse marking a received frame's alignment word |
| fas_rx | input | 10 | Received alignment bits, bit 9 first received |
| fas_exp | input | 10 | Expected alignment word (normally 10'b1111010000) |
| oof | input | 1 | Out-of-frame indication from the framer |
| mode | input | 2 | Event select: 00 OOF entries, 01 bit errors, 10 word errors, 11 reserved |
| count_en | input | 1 | Enables counting in modes 01 and 10 |
| latch_req | input | 1 | Copies the running count to the holding register and restarts the count |
| hold_count | output | 16 | Count captured by the most recent latch |

## Verification
Directed frames are applied with the received word equal to the expected word, with one bit flipped, and fully inverted. These show whether the bit-error mode adds the population count (0, 1, 10) and whether the word-error mode collapses each frame to 0 or 1. For out-of-frame entry counting, `oof` is held high across several cycles and pulsed twice. This separates edge counting from level counting. The same pattern is then applied in the other modes to show that edges are ignored there. Strobes with `oof` high, with the enable low, and in the reserved mode must leave the count unchanged. A latch issued together with a 10-error frame shows which interval the event is counted in. Thousands of full-error frames drive the count to its ceiling. Random traffic across all modes with random latch points is then compared against a bench model.

// File: rtl/e3fec_pkg.sv
package e3fec_pkg;
    parameter int FAS_W = 10;
    parameter int CNT_W = 16;
    localparam int INC_W = $clog2(FAS_W + 1);

    typedef enum logic [1:0] {
        MODE_OOF  = 2'b00,
        MODE_BITS = 2'b01,
        MODE_WORD = 2'b10,
        MODE_RSVD = 2'b11
    } cnt_mode_e;
endpackage

// File: rtl/e3fec_fas_cmp.sv
module e3fec_fas_cmp
    import e3fec_pkg::*;
#(
    parameter int W   = FAS_W,
    parameter int IW  = $clog2(W + 1)
) (
    input  logic [W-1:0]  fas_rx,
    input  logic [W-1:0]  fas_exp,
    output logic [IW-1:0] mis_cnt,
    output logic          mis_any
);
    logic [W-1:0] diff;

    // Per-position mismatch flags
    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_diff
            assign diff[g] = fas_rx[g] ^ fas_exp[g];
        end
    endgenerate

    // Population count of mismatches
    always_comb begin
        logic [IW-1:0] acc;
        acc = '0;
        for (int i = 0; i < W; i++) begin
            acc = acc + {{(IW-1){1'b0}}, diff[i]};
        end
        mis_cnt = acc;
    end

    assign mis_any = |diff;
endmodule

// File: rtl/e3fec_oof_edge.sv
module e3fec_oof_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic oof,
    output logic oof_rise
);
    typedef struct packed {
        logic prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = oof;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign oof_rise = oof & ~st_q.prev;
endmodule

// File: rtl/e3fec_evt_sel.sv
module e3fec_evt_sel
    import e3fec_pkg::*;
#(
    parameter int IW = INC_W
) (
    input  logic [1:0]    mode,
    input  logic          oof_rise,
    input  logic          frame_stb,
    input  logic          oof,
    input  logic          count_en,
    input  logic [IW-1:0] mis_cnt,
    input  logic          mis_any,
    output logic [IW-1:0] inc
);
    cnt_mode_e mode_e;
    logic      fas_ok;

    assign mode_e = cnt_mode_e'(mode);
    // Alignment checks only count with a frame strobe, in frame, and enabled
    assign fas_ok = frame_stb & ~oof & count_en;

    always_comb begin
        inc = '0;
        unique case (mode_e)
            MODE_OOF:  inc = {{(IW-1){1'b0}}, oof_rise};
            MODE_BITS: inc = fas_ok ? mis_cnt : '0;
            MODE_WORD: inc = {{(IW-1){1'b0}}, fas_ok & mis_any};
            MODE_RSVD: inc = '0;
            default:   inc = '0;
        endcase
    end
endmodule

// File: rtl/e3fec_sat_cnt.sv
module e3fec_sat_cnt
    import e3fec_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int IW = INC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] inc,
    input  logic          latch_req,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] hold
);
    localparam logic [CW:0] CEIL = {1'b0, {CW{1'b1}}};

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] hold;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        logic [CW:0] base;
        logic [CW:0] sum;
        st_d = st_q;
        // A latch restarts the interval; the current event goes into the new one
        base = latch_req ? '0 : {1'b0, st_q.cnt};
        sum  = base + {{(CW+1-IW){1'b0}}, inc};
        if (latch_req) begin
            st_d.hold = st_q.cnt;
        end
        st_d.cnt = (sum > CEIL) ? {CW{1'b1}} : sum[CW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt  = st_q.cnt;
    assign hold = st_q.hold;
endmodule

// File: rtl/e3_fas_err_counter.sv
module e3_fas_err_counter
    import e3fec_pkg::*;
#(
    parameter int FW = FAS_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_stb,
    input  logic [FW-1:0] fas_rx,
    input  logic [FW-1:0] fas_exp,
    input  logic          oof,
    input  logic [1:0]    mode,
    input  logic          count_en,
    input  logic          latch_req,
    output logic [CW-1:0] hold_count
);
    localparam int IW = $clog2(FW + 1);

    logic [IW-1:0] mis_cnt;
    logic          mis_any;
    logic          oof_rise;
    logic [IW-1:0] inc;
    logic [CW-1:0] live_cnt;

    e3fec_fas_cmp #(.W(FW), .IW(IW)) u_cmp (
        .fas_rx  (fas_rx),
        .fas_exp (fas_exp),
        .mis_cnt (mis_cnt),
        .mis_any (mis_any)
    );

    e3fec_oof_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .oof      (oof),
        .oof_rise (oof_rise)
    );

    e3fec_evt_sel #(.IW(IW)) u_sel (
        .mode      (mode),
        .oof_rise  (oof_rise),
        .frame_stb (frame_stb),
        .oof       (oof),
        .count_en  (count_en),
        .mis_cnt   (mis_cnt),
        .mis_any   (mis_any),
        .inc       (inc)
    );

    e3fec_sat_cnt #(.CW(CW), .IW(IW)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc       (inc),
        .latch_req (latch_req),
        .cnt       (live_cnt),
        .hold      (hold_count)
    );
endmodule

// File: rtl/e3fec_checker.sv
module e3fec_checker #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    mode,
    input logic          oof,
    input logic          latch_req,
    input logic [CW-1:0] cnt_q,
    input logic [CW-1:0] hold_q
);
    // R5: reserved mode never moves the count
    p_rsvd_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11 && !latch_req) |=> $stable(cnt_q));

    // R6: alignment modes are frozen while out of frame
    p_oof_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 2'b01 || mode == 2'b10) && oof && !latch_req) |=> $stable(cnt_q));

    // R4: word mode adds at most one per cycle
    p_word_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10 && !latch_req) |=> ((cnt_q - $past(cnt_q)) <= 1));

    // R8: once at the ceiling the count stays there
    p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == {CW{1'b1}} && !latch_req) |=> (cnt_q == {CW{1'b1}}));

    // R9: latch captures the prior running count
    p_latch_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        latch_req |=> (hold_q == $past(cnt_q)));

    // R10: after a latch the new interval holds at most one cycle of events
    p_new_interval_r10: assert property (@(posedge clk) disable iff (!rst_n)
        latch_req |=> (cnt_q <= 10));
endmodule

bind e3_fas_err_counter e3fec_checker #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .oof       (oof),
    .latch_req (latch_req),
    .cnt_q     (live_cnt),
    .hold_q    (hold_count)
);

// File: tb/e3_fas_err_counter_test.sv
module e3_fas_err_counter_test;
    localparam logic [9:0] FAS = 10'b1111010000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_stb = 1'b0;
    logic [9:0]  fas_rx = FAS;
    logic [9:0]  fas_exp = FAS;
    logic        oof = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic        count_en = 1'b0;
    logic        latch_req = 1'b0;
    logic [15:0] hold_count;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Bench model state
    int unsigned m_cnt = 0;
    int unsigned m_hold = 0;
    logic        m_prev = 1'b0;

    e3_fas_err_counter uut (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .fas_rx(fas_rx),
        .fas_exp(fas_exp), .oof(oof), .mode(mode), .count_en(count_en),
        .latch_req(latch_req), .hold_count(hold_count)
    );

    always #4 clk = ~clk;

    function automatic int unsigned popmis(logic [9:0] a, logic [9:0] b);
        int unsigned n = 0;
        for (int i = 0; i < 10; i++) n += (a[i] != b[i]) ? 1 : 0;
        return n;
    endfunction

    function automatic int unsigned events(logic [1:0] md, logic stb, logic o,
                                           logic prev, logic en,
                                           logic [9:0] rx, logic [9:0] ex);
        bit ok = stb && !o && en;
        case (md)
            2'b00:   return (o && !prev) ? 1 : 0;
            2'b01:   return ok ? popmis(rx, ex) : 0;
            2'b10:   return (ok && popmis(rx, ex) != 0) ? 1 : 0;
            default: return 0;
        endcase
    endfunction

    task automatic report();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic check(int unsigned act, int unsigned exp, string req);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock: inputs are stable from the previous negedge
    task automatic cyc();
        int unsigned inc;
        int unsigned sum;
        @(posedge clk);
        inc = events(mode, frame_stb, oof, m_prev, count_en, fas_rx, fas_exp);
        if (rst_n) begin
            if (latch_req) begin
                m_hold = m_cnt;
                sum = inc;
            end else begin
                sum = m_cnt + inc;
            end
            m_cnt = (sum > 65535) ? 65535 : sum;
            m_prev = oof;
        end
        @(negedge clk);
    endtask

    task automatic frame(logic [9:0] rx);
        frame_stb = 1'b1; fas_rx = rx;
        cyc();
        frame_stb = 1'b0; fas_rx = FAS;
    endtask

    task automatic take(int unsigned exp, string req);
        latch_req = 1'b1;
        cyc();
        latch_req = 1'b0;
        check(hold_count, exp, req);
    endtask

    initial begin
        #(8 * 200000);
        checks++;
        failures++;
        $display("FAIL WATCHDOG: actual=timeout expected=finish");
        report();
    end

    initial begin
        void'($urandom(32'hE3F0_0751));
        @(negedge clk);
        cyc(); cyc();
        rst_n = 1'b1;
        check(hold_count, 0, "R1 reset");
        take(0, "R1 first latch");

        // R2: edges only, enable and strobe mismatches irrelevant
        mode = 2'b00; count_en = 1'b0;
        oof = 1'b1; repeat (5) cyc();
        oof = 1'b0; repeat (2) cyc();
        oof = 1'b1; frame(~FAS); repeat (2) cyc();
        oof = 1'b0; frame(~FAS);
        take(2, "R2 oof entries");
        oof = 1'b1; cyc(); oof = 1'b0; count_en = 1'b1; cyc();
        take(1, "R2 enable ignored");
        frame(~FAS); frame(FAS ^ 10'h001);
        take(0, "R7 mismatches in oof mode");

        // R3: bit errors
        mode = 2'b01;
        frame(~FAS); frame(FAS ^ 10'h200); frame(FAS);
        fas_rx = ~FAS; cyc(); fas_rx = FAS;
        take(11, "R3 bit count");
        frame(FAS ^ 10'h0F0);
        take(4, "R3 four bits");

        // R4: word errors
        mode = 2'b10;
        frame(~FAS); frame(FAS ^ 10'h200); frame(FAS); frame(FAS ^ 10'h00C);
        take(3, "R4 word count");

        // R5: reserved
        mode = 2'b11;
        frame(~FAS); oof = 1'b1; cyc(); oof = 1'b0; frame(~FAS);
        take(0, "R5 reserved");

        // R6/R7: suppression in alignment modes
        mode = 2'b01; oof = 1'b1;
        frame(~FAS); frame(~FAS);
        oof = 1'b0; cyc();
        take(0, "R6 oof suppress bits, R7 edge ignored");
        mode = 2'b10; oof = 1'b1; frame(~FAS); oof = 1'b0;
        take(0, "R6 oof suppress word");
        mode = 2'b01; count_en = 1'b0; frame(~FAS);
        take(0, "R6 enable off");
        count_en = 1'b1;

        // R10: event in latch cycle joins the new interval
        frame(FAS ^ 10'h003);
        frame_stb = 1'b1; fas_rx = ~FAS; latch_req = 1'b1;
        cyc();
        frame_stb = 1'b0; fas_rx = FAS; latch_req = 1'b0;
        check(hold_count, 2, "R9 latched prior count");
        take(10, "R10 latch-cycle event");

        // R8: saturation
        repeat (6600) frame(~FAS);
        take(65535, "R8 saturate");
        take(0, "R9 cleared after latch");

        // Random traffic against the model
        for (int i = 0; i < 5000; i++) begin
            mode      = 2'($urandom_range(0, 3));
            count_en  = 1'($urandom_range(0, 3) != 0);
            frame_stb = 1'($urandom_range(0, 2) == 0);
            oof       = 1'($urandom_range(0, 5) == 0);
            fas_rx    = ($urandom_range(0, 1) == 0) ? FAS : (FAS ^ 10'($urandom));
            latch_req = 1'($urandom_range(0, 40) == 0);
            cyc();
            if (latch_req) check(hold_count, m_hold, "R3 R4 R2 random model");
        end
        frame_stb = 1'b0; oof = 1'b0; latch_req = 1'b0;
        take(m_cnt, "R9 random final");
        report();
    end
endmodule